// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital sequencer for a dual-slope integrating analog-to-digital converter. A single request starts a conversion. The sequencer first clears the integrator and captures the input on the sample-and-hold. It then connects the held input to the integrator for a fixed run-up of exactly 2^N clocks. After that it switches the integrator to the opposite-polarity reference and counts clocks until the comparator reports that the integrator has returned to zero. That count is the conversion code.

Both slopes are timed by the same clock and the same N-bit counter. Clock-frequency and RC-product errors therefore cancel, and the code approximates input/reference × 2^N. The end of the run-up is marked by the counter wrapping from all ones back to zero, so no separate length comparison is needed. If the run-down reaches the last count value while the comparator still reads above zero, the code saturates and an overrange flag is raised.

The integrator, comparator and sample-and-hold are outside the block. The block only drives their control switches and reads the comparator bit, which it takes to be synchronous to the clock.

Top module: `dslope_seq`

## Requirements
- R1: When `startReq` is high in a cycle where `busy` is low, `intClear` is high in the next cycle for exactly one cycle. `holdCapture` is then high for exactly one cycle directly after it, and `busy` rises together with `intClear`.
- R2: After the capture cycle, `integEn` is high and `selRef` is low (held input connected) for exactly 2^N consecutive cycles.
- R3: Directly after the run-up, `integEn` and `selRef` are both high (reference connected). They stay high through the cycle in which the conversion is decided. `selRef` is never high while `integEn` is low.
- R4: Number the run-down cycles from 0. The code is the number k of the first run-down cycle in which `cmpAbove` is sampled low. With a linear integrator this equals ceil(2^N × input / reference).
- R5: If `cmpAbove` is still high in run-down cycle 2^N−1, then `code` becomes all ones and `overRange` becomes 1. A normal decision clears `overRange` to 0.
- R6: `done` is high for exactly one cycle, in the cycle after the deciding run-down cycle, and `code` and `overRange` already hold the new result in that cycle. `busy` stays high up to and including the `done` cycle, then goes low.
- R7: `code` and `overRange` keep their values from one `done` cycle until the next result update.
- R8: Synchronous active-high `rst` returns the block to idle, even in the middle of a conversion. After reset, `busy`, `done`, `integEn`, `selRef`, `intClear`, `holdCapture`, `overRange` and `code` are all 0.
- R9: `startReq` has no effect while `busy` is high: no additional clear, capture or `done` pulse occurs, and the run-up length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing derives from it |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Starts a conversion when the block is idle |
| cmpAbove | input | 1 | Comparator: 1 while the integrator output is above zero |
| integEn | output | 1 | Connects an input to the integrator (run-up and run-down) |
| selRef | output | 1 | Integrator source: 0 = held input, 1 = reference |
| intClear | output | 1 | Integrator reset switch, one-cycle pulse |
| holdCapture | output | 1 | Sample-and-hold capture, one-cycle pulse |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle pulse when a new result is presented |
| overRange | output | 1 | Last result saturated |
| code | output | CNT_W | Conversion result (run-down count) |

## Verification
The assertions assume that `cmpAbove` changes only just after a clock edge. They also assume that the integrator ramps monotonically: upward while the held input is connected, and downward while the reference is connected. Without this, the comparator could flicker during run-down, and a code taken from the first low sample would be meaningless. The stimulus meets these assumptions with an integer integrator model that updates only on clock edges, using a non-negative input amplitude and a positive reference amplitude. Its test values cover a zero input, the single-step and half-scale codes, the largest code that does not saturate, exact full scale, and inputs above full scale. A start request during run-up and a reset in the middle of a conversion are also applied.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_HOLD,
    ST_UP,
    ST_DOWN,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic takeCount;
    logic takeSat;
  } dpStrobe_t;

endpackage

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       cmpAbove,
  input  logic       cntMax,
  output dpStrobe_t  strobe,
  output logic       integEn,
  output logic       selRef,
  output logic       intClear,
  output logic       holdCapture,
  output logic       busy,
  output logic       done
);

  seqState_t curState;
  seqState_t nxtState;

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    strobe   = '0;
    case (curState)
      ST_IDLE: begin
        if (startReq) nxtState = ST_CLR;
      end
      ST_CLR: begin
        nxtState = ST_HOLD;
      end
      ST_HOLD: begin
        // counter starts from zero for the fixed run-up
        strobe.cntClear = 1'b1;
        nxtState        = ST_UP;
      end
      ST_UP: begin
        // wrap from all ones to zero ends run-up and re-arms the count
        strobe.cntInc = 1'b1;
        if (cntMax) nxtState = ST_DOWN;
      end
      ST_DOWN: begin
        if (!cmpAbove) begin
          strobe.takeCount = 1'b1;
          nxtState         = ST_DONE;
        end else if (cntMax) begin
          strobe.takeSat = 1'b1;
          nxtState       = ST_DONE;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_DONE: begin
        nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign intClear    = (curState == ST_CLR);
  assign holdCapture = (curState == ST_HOLD);
  assign integEn     = (curState == ST_UP) || (curState == ST_DOWN);
  assign selRef      = (curState == ST_DOWN);
  assign busy        = (curState != ST_IDLE);
  assign done        = (curState == ST_DONE);

endmodule

// File: rtl/dslope_dp.sv
module dslope_dp
  import dslope_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  output logic             cntMax,
  output logic [CNT_W-1:0] code,
  output logic             overRange
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (rst)                  phaseCnt <= '0;
    else if (strobe.cntClear) phaseCnt <= '0;
    else if (strobe.cntInc)   phaseCnt <= phaseCnt + 1'b1;
  end

  assign cntMax = (phaseCnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      code      <= '0;
      overRange <= 1'b0;
    end else if (strobe.takeCount) begin
      code      <= phaseCnt;
      overRange <= 1'b0;
    end else if (strobe.takeSat) begin
      code      <= CNT_TOP;
      overRange <= 1'b1;
    end
  end

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             cmpAbove,
  output logic             integEn,
  output logic             selRef,
  output logic             intClear,
  output logic             holdCapture,
  output logic             busy,
  output logic             done,
  output logic             overRange,
  output logic [CNT_W-1:0] code
);

  dpStrobe_t strobe;
  logic      cntMax;

  dslope_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .startReq    (startReq),
    .cmpAbove    (cmpAbove),
    .cntMax      (cntMax),
    .strobe      (strobe),
    .integEn     (integEn),
    .selRef      (selRef),
    .intClear    (intClear),
    .holdCapture (holdCapture),
    .busy        (busy),
    .done        (done)
  );

  dslope_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .cntMax    (cntMax),
    .code      (code),
    .overRange (overRange)
  );

endmodule

// File: rtl/dslope_chk.sv
module dslope_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             startReq,
  input logic             integEn,
  input logic             selRef,
  input logic             intClear,
  input logic             holdCapture,
  input logic             busy,
  input logic             done,
  input logic             overRange,
  input logic [CNT_W-1:0] code
);

  localparam int SPAN = 1 << CNT_W;

  logic [CNT_W:0] upCyc;

  always_ff @(posedge clk) begin
    if (rst)                     upCyc <= '0;
    else if (integEn && !selRef) upCyc <= upCyc + 1'b1;
    else                         upCyc <= '0;
  end

  p_start_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && startReq) |=> (intClear && busy));

  p_clear_then_hold_r1: assert property (@(posedge clk) disable iff (rst)
    intClear |=> (holdCapture && !intClear));

  p_runup_len_r2: assert property (@(posedge clk) disable iff (rst)
    (integEn && !selRef && upCyc == (CNT_W+1)'(SPAN - 1)) |=> (integEn && selRef));

  p_runup_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (integEn && !selRef) |-> (upCyc < (CNT_W+1)'(SPAN)));

  p_sel_within_r3: assert property (@(posedge clk) disable iff (rst)
    selRef |-> integEn);

  p_sat_code_r5: assert property (@(posedge clk) disable iff (rst)
    (done && overRange) |-> (code == {CNT_W{1'b1}}));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(code) && $stable(overRange)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!integEn && !intClear && !holdCapture && !done));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && startReq) |=> !intClear);

endmodule

bind dslope_seq dslope_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .startReq    (startReq),
  .integEn     (integEn),
  .selRef      (selRef),
  .intClear    (intClear),
  .holdCapture (holdCapture),
  .busy        (busy),
  .done        (done),
  .overRange   (overRange),
  .code        (code)
);

// File: tb/sim_dslope_seq.sv
module sim_dslope_seq;

  localparam int W    = 8;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         startReq = 1'b0;
  logic         cmpAbove;
  logic         integEn, selRef, intClear, holdCapture, busy, done, overRange;
  logic [W-1:0] code;

  always #5 clk = ~clk;

  dslope_seq #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .startReq(startReq), .cmpAbove(cmpAbove),
    .integEn(integEn), .selRef(selRef), .intClear(intClear),
    .holdCapture(holdCapture), .busy(busy), .done(done),
    .overRange(overRange), .code(code)
  );

  // integrator model: ramps by input amplitude, ramps down by reference
  int vInt = 0;
  int vinAmp = 0;
  int vrefAmp = 1;

  always @(posedge clk) begin
    if (intClear)     vInt <= 0;
    else if (integEn) vInt <= selRef ? (vInt - vrefAmp) : (vInt + vinAmp);
  end
  assign cmpAbove = (vInt > 0);

  typedef struct {
    int code;
    bit ovr;
    int rdLen;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad   = 0;
  int upCnt = 0;
  int dnCnt = 0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: counts phase lengths, pops expected results on done
  always @(negedge clk) begin
    if (rst) begin
      upCnt = 0;
      dnCnt = 0;
    end else begin
      if (integEn && !selRef) upCnt++;
      if (integEn && selRef)  dnCnt++;
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(int'(code) == it.code, "R4/R5 code", int'(code), it.code);
          check(overRange == it.ovr, "R5 overRange", int'(overRange), int'(it.ovr));
          check(upCnt == SPAN, "R2 run-up length", upCnt, SPAN);
          check(dnCnt == it.rdLen, "R3 run-down length", dnCnt, it.rdLen);
          check(busy == 1'b1, "R6 busy with done", int'(busy), 1);
        end
        upCnt = 0;
        dnCnt = 0;
      end
    end
  end

  task automatic convert(int a, int b, bit poke);
    expItem_t it;
    int e;
    vinAmp  = a;
    vrefAmp = b;
    e = (SPAN * a + b - 1) / b;
    if (e > SPAN - 1) begin
      it.code = SPAN - 1; it.ovr = 1'b1; it.rdLen = SPAN;
    end else begin
      it.code = e; it.ovr = 1'b0; it.rdLen = e + 1;
    end
    expQ.push_back(it);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    check(intClear && busy, "R1 clear pulse", int'(intClear), 1);
    @(negedge clk);
    check(holdCapture && !intClear, "R1 capture pulse", int'(holdCapture), 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      startReq = 1'b1;
      @(negedge clk) startReq = 1'b0;
      check(!intClear, "R9 start ignored", int'(intClear), 0);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!busy, "R6 busy falls", int'(busy), 0);
    check(!done, "R6 done single", int'(done), 0);
    repeat (5) @(negedge clk);
    check(int'(code) == it.code, "R7 code held", int'(code), it.code);
    check(overRange == it.ovr, "R7 flag held", int'(overRange), int'(it.ovr));
    check(expQ.size() == 0, "R6 result delivered", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done, "R8 reset busy/done", int'(busy), 0);
    check(code == '0, "R8 reset code", int'(code), 0);
    check(!overRange, "R8 reset flag", int'(overRange), 0);
    check(!integEn && !selRef && !intClear && !holdCapture, "R8 reset switches",
          int'(integEn), 0);
    rst = 1'b0;
    @(negedge clk);

    convert(0, 100, 1'b0);      // zero input, code 0
    convert(1, 256, 1'b0);      // single step
    convert(128, 256, 1'b0);    // half scale
    convert(37, 100, 1'b1);     // rounded up, start poked during run-up
    convert(255, 256, 1'b0);    // largest non-saturating code
    convert(256, 256, 1'b0);    // exact full scale saturates
    convert(300, 256, 1'b0);    // above full scale
    convert(10, 256, 1'b0);     // flag clears after saturation
    convert(50, 3, 1'b0);       // far over range

    // reset during run-up
    vinAmp = 100; vrefAmp = 200;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(!busy && !integEn, "R8 abort to idle", int'(busy), 0);
    check(code == '0 && !overRange, "R8 abort clears result", int'(code), 0);
    repeat (600) @(negedge clk);
    check(!busy, "R8 stays idle", int'(busy), 0);

    convert(200, 256, 1'b0);    // normal after abort

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule